// File: doc/BRIEF.md
# Load/Store Address and Memory Sequencer

This block runs the data-movement instructions of a small 16-bit register machine. It takes three inputs: a fetched instruction word, the program counter value that fetch has already incremented, and the operand values from the register file. From these it computes an effective address, performs one or two accesses on a single-port synchronous memory that answers with a ready handshake, and hands a result back to the register file through a one-cycle write-back strobe.

Four addressing forms share one 16-bit adder. The PC-relative form adds a 9-bit signed offset to the PC. The base-plus-offset form adds a 6-bit signed offset to a base register. The indirect form reads a pointer word at a PC-relative location and then accesses the address held in that word. The address-only form writes the computed address itself into a register and does not touch memory. A start pulse launches one instruction. A done pulse marks its end.

Top module: `ldst_seq`

## Requirements
- R1: Opcode field instr[15:12] selects the operation: 0010 load PC-relative, 0011 store PC-relative, 0110 load base-plus-offset, 0111 store base-plus-offset, 1010 load indirect, 1011 store indirect, 1110 load effective address. A start with any other opcode raises `illegal` for exactly the following cycle, performs no memory access and no write-back, and leaves the block idle.
- R2: PC-relative forms use address `pc_next + sext(instr[8:0])`. A load writes the memory word to register instr[11:9]. A store writes that register's value to memory.
- R3: Base-plus-offset forms use address `R[instr[8:6]] + sext(instr[5:0])`, with the register number for data in instr[11:9].
- R4: Indirect forms first read memory at `pc_next + sext(instr[8:0])`. The returned word is the address of the second access, a read for the load or a write for the store.
- R5: The effective-address form writes `pc_next + sext(instr[8:0])` to register instr[11:9] and issues no memory request.
- R6: All address sums wrap modulo 2^16.
- R7: A request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until a clock edge at which `mem_ready` is high. That edge completes the access.
- R8: `done` is high for exactly one cycle. That cycle directly follows either the write-back cycle or the completing edge of a store's final access. `busy` is high from the cycle after an accepted start up to and including the done cycle.
- R9: A start that arrives while `busy` is high, including in the done cycle, is ignored and changes no result.
- R10: Loads and the effective-address form produce exactly one write-back cycle. Stores produce none. No write-back cycle carries a memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| instr | input | 16 | Instruction word, sampled with start |
| pc_next | input | 16 | Already-incremented PC, sampled with start |
| src_sel | output | 3 | Register-file read index for store data |
| src_data | input | 16 | Register value at src_sel |
| base_sel | output | 3 | Register-file read index for the base register |
| base_data | input | 16 | Register value at base_sel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable of the current access |
| mem_addr | output | 16 | Address of the current access |
| mem_wdata | output | 16 | Write data of the current access |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the pending access |
| wb_en | output | 1 | Register write-back strobe |
| wb_sel | output | 3 | Write-back register index |
| wb_data | output | 16 | Write-back value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse after a start with an unsupported opcode |

## Verification
Two things can happen in the same cycle: a new start pulse, and the done pulse or a pending memory wait of the previous instruction. The bench raises start, with a different instruction word and PC on the ports, in the same cycle that done is visible. It also raises start while an indirect access is stalled on `mem_ready`. In both cases the cycle-level model expects exactly the accesses and write-back of the first instruction and an idle block afterwards, so any extra request or write-back, or a busy flag left high, is reported. Memory latencies of zero to three wait cycles also let the pointer read complete on the very edge where the second access is prepared.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int WORD_W     = 16;
  localparam int OPC_W      = 4;
  localparam int REGSEL_W   = 3;
  localparam int OFF_PC_W   = 9;
  localparam int OFF_BASE_W = 6;

  localparam int OPC_LSB    = WORD_W - OPC_W;
  localparam int DST_LSB    = OPC_LSB - REGSEL_W;
  localparam int BASE_LSB   = DST_LSB - REGSEL_W;

  typedef enum logic [OPC_W-1:0] {
    OP_LD_PC   = 4'b0010,
    OP_ST_PC   = 4'b0011,
    OP_LD_BASE = 4'b0110,
    OP_ST_BASE = 4'b0111,
    OP_LD_IND  = 4'b1010,
    OP_ST_IND  = 4'b1011,
    OP_LEA     = 4'b1110
  } opcode_e;

  typedef enum logic [2:0] {
    AM_PCREL,
    AM_BASE,
    AM_INDIR,
    AM_LEA,
    AM_NONE
  } amode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_MEM1,
    SQ_MEM2,
    SQ_WB,
    SQ_DONE
  } seq_state_e;

  typedef struct packed {
    logic   legal;
    amode_e mode;
    logic   is_store;
  } dec_t;

  function automatic logic [WORD_W-1:0] sext_pc(input logic [OFF_PC_W-1:0] f);
    return {{(WORD_W-OFF_PC_W){f[OFF_PC_W-1]}}, f};
  endfunction

  function automatic logic [WORD_W-1:0] sext_base(input logic [OFF_BASE_W-1:0] f);
    return {{(WORD_W-OFF_BASE_W){f[OFF_BASE_W-1]}}, f};
  endfunction

  function automatic logic [WORD_W-1:0] wrap_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);

  always_comb begin
    dec = '{legal: 1'b1, mode: AM_NONE, is_store: 1'b0};
    unique case (opc)
      OP_LD_PC:   dec.mode = AM_PCREL;
      OP_ST_PC:   begin dec.mode = AM_PCREL; dec.is_store = 1'b1; end
      OP_LD_BASE: dec.mode = AM_BASE;
      OP_ST_BASE: begin dec.mode = AM_BASE;  dec.is_store = 1'b1; end
      OP_LD_IND:  dec.mode = AM_INDIR;
      OP_ST_IND:  begin dec.mode = AM_INDIR; dec.is_store = 1'b1; end
      OP_LEA:     dec.mode = AM_LEA;
      default:    dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_pkg::*;
(
  input  amode_e            mode,
  input  logic [OFF_PC_W-1:0] offs,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] base,
  output logic [WORD_W-1:0] ea
);

  logic [WORD_W-1:0] opa;
  logic [WORD_W-1:0] opb;

  // a single adder serves every form; only its operands are steered
  always_comb begin
    if (mode == AM_BASE) begin
      opa = base;
      opb = sext_base(offs[OFF_BASE_W-1:0]);
    end else begin
      opa = pc;
      opb = sext_pc(offs);
    end
    ea = wrap_add(opa, opb);
  end

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WORD_W-1:0]   instr,
  input  logic [WORD_W-1:0]   pc_next,
  output logic [REGSEL_W-1:0] src_sel,
  input  logic [WORD_W-1:0]   src_data,
  output logic [REGSEL_W-1:0] base_sel,
  input  logic [WORD_W-1:0]   base_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  output logic                wb_en,
  output logic [REGSEL_W-1:0] wb_sel,
  output logic [WORD_W-1:0]   wb_data,
  output logic                busy,
  output logic                done,
  output logic                illegal
);

  seq_state_e        state_q;
  logic [WORD_W-1:0] ir_q;
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              illegal_q;

  // decode the incoming word while idle, the held word otherwise
  logic [WORD_W-1:0] dec_word;
  dec_t              dec;
  logic [WORD_W-1:0] ea;

  assign dec_word = (state_q == SQ_IDLE) ? instr : ir_q;

  ldst_decode u_dec (
    .opc (dec_word[WORD_W-1 -: OPC_W]),
    .dec (dec)
  );

  ldst_agen u_agen (
    .mode (dec.mode),
    .offs (ir_q[OFF_PC_W-1:0]),
    .pc   (pc_q),
    .base (base_data),
    .ea   (ea)
  );

  // named internal events, used by the bound checker
  logic   ev_accept;
  logic   ev_reject;
  logic   ev_hs;
  logic   ev_final_store;
  amode_e cur_mode;
  logic   cur_store;

  assign ev_accept      = start && (state_q == SQ_IDLE) && dec.legal;
  assign ev_reject      = start && (state_q == SQ_IDLE) && !dec.legal;
  assign ev_hs          = mem_req && mem_ready;
  assign ev_final_store = ev_hs && (state_q == SQ_MEM2) && dec.is_store;
  assign cur_mode       = dec.mode;
  assign cur_store      = dec.is_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      ir_q      <= '0;
      pc_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= ev_reject;
      unique case (state_q)
        SQ_IDLE: begin
          if (ev_accept) begin
            ir_q    <= instr;
            pc_q    <= pc_next;
            state_q <= SQ_ADDR;
          end
        end
        SQ_ADDR: begin
          addr_q <= ea;
          if (dec.mode == AM_LEA) begin
            data_q  <= ea;
            state_q <= SQ_WB;
          end else begin
            data_q  <= src_data;
            state_q <= (dec.mode == AM_INDIR) ? SQ_MEM1 : SQ_MEM2;
          end
        end
        SQ_MEM1: begin
          if (ev_hs) begin
            addr_q  <= mem_rdata;
            state_q <= SQ_MEM2;
          end
        end
        SQ_MEM2: begin
          if (ev_hs) begin
            if (dec.is_store) begin
              state_q <= SQ_DONE;
            end else begin
              data_q  <= mem_rdata;
              state_q <= SQ_WB;
            end
          end
        end
        SQ_WB:   state_q <= SQ_DONE;
        SQ_DONE: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign src_sel   = ir_q[DST_LSB +: REGSEL_W];
  assign base_sel  = ir_q[BASE_LSB +: REGSEL_W];
  assign mem_req   = (state_q == SQ_MEM1) || (state_q == SQ_MEM2);
  assign mem_we    = (state_q == SQ_MEM2) && dec.is_store;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign wb_en     = (state_q == SQ_WB);
  assign wb_sel    = ir_q[DST_LSB +: REGSEL_W];
  assign wb_data   = data_q;
  assign busy      = (state_q != SQ_IDLE);
  assign done      = (state_q == SQ_DONE);
  assign illegal   = illegal_q;

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk
  import ldst_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              wb_en,
  input logic [WORD_W-1:0] ir_q,
  input amode_e            cur_mode,
  input logic              cur_store
);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wb_en) || $past(mem_req && mem_ready && mem_we));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_wb_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !mem_req && !cur_store);

  assert_illegal_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !mem_req && !wb_en);

  assert_lea_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cur_mode != AM_LEA);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(ir_q));

endmodule

bind ldst_seq ldst_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .wb_en     (wb_en),
  .ir_q      (ir_q),
  .cur_mode  (cur_mode),
  .cur_store (cur_store)
);

// File: tb/ldst_seq_tb.sv
module ldst_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_next = '0;
  logic [2:0]  src_sel, base_sel, wb_sel;
  logic [15:0] src_data, base_data;
  logic        mem_req, mem_we, mem_ready, wb_en, busy, done, illegal;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, wb_data;

  always #2.5 clk = ~clk;

  logic [15:0] rf [8];
  logic [15:0] mem [int];
  assign src_data  = rf[src_sel];
  assign base_data = rf[base_sel];

  ldst_seq u_dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int lat_cfg = 0;
  string cur_tag = "R2";

  typedef struct { int addr; bit we; int wdata; } acc_t;
  typedef struct { int r; int d; } wb_t;
  acc_t acc_q[$];
  wb_t  wb_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rdm(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  // cycle-level model of memory and register file, compared every clock
  bit done_exp = 0;
  bit prev_wait = 0;
  int prev_addr = 0;
  int wait_cnt = 0;
  initial begin mem_ready = 1'b0; mem_rdata = '0; end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done === done_exp, "R8", "done", int'(done), int'(done_exp));
      if (prev_wait)
        chk(mem_req && int'(mem_addr) == prev_addr, "R7", "held request addr",
            int'(mem_addr), prev_addr);
      done_exp = 0;
      prev_wait = 0;
      if (wb_en) begin
        if (wb_q.size() == 0) begin
          chk(0, "R10", "unexpected write-back", int'(wb_sel), -1);
        end else begin
          chk(int'(wb_sel) == wb_q[0].r, cur_tag, "wb register", int'(wb_sel), wb_q[0].r);
          chk(int'(wb_data) == wb_q[0].d, cur_tag, "wb data", int'(wb_data), wb_q[0].d);
          void'(wb_q.pop_front());
        end
        rf[wb_sel] = wb_data;
        done_exp = 1;
      end
      if (mem_req) begin
        if (wait_cnt >= lat_cfg) begin
          mem_ready = 1'b1;
          mem_rdata = rdm(int'(mem_addr));
          wait_cnt = 0;
          if (acc_q.size() == 0) begin
            chk(0, cur_tag, "unexpected memory access", int'(mem_addr), -1);
          end else begin
            chk(int'(mem_addr) == acc_q[0].addr, cur_tag, "access addr",
                int'(mem_addr), acc_q[0].addr);
            chk(mem_we == acc_q[0].we, cur_tag, "access we", int'(mem_we), int'(acc_q[0].we));
            if (acc_q[0].we)
              chk(int'(mem_wdata) == acc_q[0].wdata, cur_tag, "store data",
                  int'(mem_wdata), acc_q[0].wdata);
            void'(acc_q.pop_front());
          end
          if (mem_we) mem[int'(mem_addr)] = mem_wdata;
          if (acc_q.size() == 0 && wb_q.size() == 0) done_exp = 1;
        end else begin
          mem_ready = 1'b0;
          wait_cnt++;
          prev_wait = 1;
          prev_addr = int'(mem_addr);
        end
      end else begin
        mem_ready = 1'b0;
        wait_cnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // spam: 0 none, 1 extra start while stalled, 2 extra start in the done cycle
  task automatic exec(input string tag, input logic [3:0] op, input int r, input int b,
                      input int off, input int pcv, input int lat, input int spam);
    logic [15:0] iw;
    int ea, p, fa;
    cur_tag = tag;
    lat_cfg = lat;
    if (op == 4'b0110 || op == 4'b0111) begin
      iw = {op, 3'(r), 3'(b), 6'(off)};
      ea = (int'(rf[b]) + off) & 32'hFFFF;
    end else begin
      iw = {op, 3'(r), 9'(off)};
      ea = (pcv + off) & 32'hFFFF;
    end
    case (op)
      4'b0010, 4'b0110: begin acc_q.push_back('{ea, 0, 0});
                              wb_q.push_back('{r, int'(rdm(ea))}); end
      4'b0011, 4'b0111: acc_q.push_back('{ea, 1, int'(rf[r])});
      4'b1010: begin p = ea; fa = int'(rdm(p));
                     acc_q.push_back('{p, 0, 0}); acc_q.push_back('{fa, 0, 0});
                     wb_q.push_back('{r, int'(rdm(fa))}); end
      4'b1011: begin p = ea; fa = int'(rdm(p));
                     acc_q.push_back('{p, 0, 0}); acc_q.push_back('{fa, 1, int'(rf[r])}); end
      default: wb_q.push_back('{r, ea});
    endcase
    instr = iw; pc_next = 16'(pcv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
    if (spam == 1) begin
      @(negedge clk);
      start = 1'b1; instr = 16'hE9FF; pc_next = 16'h7777;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (spam == 2) begin
      start = 1'b1; instr = 16'hEE05; pc_next = 16'h5555;
    end
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0, (spam != 0) ? "R9" : "R8", "busy after done", int'(busy), 0);
    chk(acc_q.size() == 0, tag, "accesses outstanding", acc_q.size(), 0);
    chk(wb_q.size() == 0, "R10", "write-backs outstanding", wb_q.size(), 0);
    acc_q.delete();
    wb_q.delete();
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, (spam != 0) ? "R9" : "R8", "still idle", int'(busy), 0);
  endtask

  task automatic bad_op(input logic [3:0] op);
    cur_tag = "R1";
    instr = {op, 12'h2A5}; pc_next = 16'h3000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(illegal === 1'b1, "R1", "illegal pulse", int'(illegal), 1);
    chk(busy === 1'b0, "R1", "idle on illegal", int'(busy), 0);
    @(negedge clk);
    chk(illegal === 1'b0, "R1", "illegal one cycle", int'(illegal), 0);
    chk(!busy && !mem_req && !wb_en, "R1", "no activity", int'(busy | mem_req | wb_en), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rf = '{16'h0000, 16'h4000, 16'hA5A5, 16'hFFFE, 16'h0020, 16'h0000, 16'h0000, 16'h0000};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !wb_en && !illegal, "R8", "reset state",
        int'({busy, done, mem_req, wb_en, illegal}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R8", "idle after reset", int'({busy, mem_req}), 0);

    mem[32'h3006] = 16'h1111; exec("R2", 4'b0010, 5, 0, 5, 16'h3001, 0, 0);
    mem[32'h2F00] = 16'h2222; exec("R2", 4'b0010, 6, 0, -256, 16'h3000, 1, 0);
    mem[32'h30FF] = 16'h3333; exec("R2", 4'b0010, 0, 0, 255, 16'h3000, 2, 0);
    exec("R2", 4'b0011, 2, 0, -1, 16'h3000, 1, 0);
    exec("R10", 4'b0010, 7, 0, -1, 16'h3000, 0, 0);
    mem[32'h3FE0] = 16'h4444; exec("R3", 4'b0110, 5, 1, -32, 16'h3000, 1, 0);
    mem[32'h003F] = 16'h5555; exec("R3", 4'b0110, 6, 4, 31, 16'h3000, 0, 0);
    exec("R6", 4'b0111, 2, 3, 3, 16'h3000, 0, 0);
    exec("R6", 4'b0110, 7, 3, 3, 16'h3000, 2, 0);
    mem[32'h300A] = 16'hFFFF; mem[32'hFFFF] = 16'hBEEF;
    exec("R4", 4'b1010, 5, 0, 10, 16'h3000, 3, 1);
    mem[32'h2FFD] = 16'hFFFF;
    exec("R4", 4'b1011, 2, 0, -3, 16'h3000, 1, 2);
    exec("R6", 4'b0010, 7, 0, -2, 16'h0001, 0, 0);
    exec("R4", 4'b1010, 1, 0, -3, 16'h3000, 0, 0);
    exec("R5", 4'b1110, 3, 0, -256, 16'h0010, 0, 0);
    exec("R5", 4'b1110, 4, 0, 255, 16'h1000, 0, 2);
    exec("R6", 4'b1110, 0, 0, 255, 16'hFFFF, 0, 0);
    bad_op(4'b0000);
    bad_op(4'b1111);
    bad_op(4'b0100);
    mem[32'h3100] = 16'h6789; exec("R1", 4'b0010, 6, 0, 255, 16'h3001, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule